// File: doc/BRIEF.md
# IR code host interface

This block connects the output of an infrared remote-control decoder to a small host processor. The decoder hands over a 7-bit device code and an 8-bit command code together with a one-cycle valid strobe. The block keeps these codes until the host collects them, and it signals pending work on a level interrupt line.

The parameter `MODE` selects one of two variants at elaboration. The direct variant keeps one device register and one command register. Each new pair overwrites them, so the host always sees the latest button press. A pending flag drives the interrupt, and the host clears that flag with an acknowledge or a read strobe. The queued variant writes each pair as two bytes into a byte-wide FIFO, device byte first. The host pops the FIFO one byte per read strobe. The interrupt then shows FIFO not-empty. In both variants a host-written enable bit gates the interrupt line but does not clear what is pending.

Top module: `ir_code_host_if`

## Requirements
- R1: A synchronous active-high reset empties the FIFO. It also clears the code registers, the pending flag and the overflow flag, and it clears the interrupt enable. While reset is applied and after it is released, `irq` and `overflow` read 0.
- R2: Direct mode: on the clock edge where `code_valid` is high, `dev_out` and `cmd_out` take the input codes. The pending flag sets at that edge, so `irq` is high from the next cycle on when enabled.
- R3: Direct mode: a new valid pair overwrites both registers even while an earlier pair is still pending, and the pending state stays set.
- R4: Direct mode: `ack` or `rd_stb` clears the pending flag at the next edge. If `code_valid` is high in the same cycle, the new pair wins and the pending flag stays set.
- R5: The enable bit is loaded from `irq_en_din` when `irq_en_wr` is high. When the enable is 0, `irq` is 0. Pending status or FIFO content is kept, so `irq` returns as soon as the enable is set again.
- R6: Queued mode: each accepted pair becomes two FIFO bytes. The first is the device code zero-extended to 8 bits (bit 7 = 0), and the second is the command code. `rd_data` shows the oldest byte while the FIFO is not empty, and each `rd_stb` pops one byte.
- R7: Queued mode: `irq` equals FIFO not-empty ANDed with the enable bit.
- R8: Queued mode: the FIFO holds `DEPTH` bytes (default 8). A pair is accepted only when at least two bytes are free, judged on the occupancy before any pop in the same cycle. Otherwise the whole pair is dropped and `overflow` sets and stays set until reset.
- R9: Queued mode: a pair and a read strobe in the same cycle are both honoured. The byte order and the occupancy stay consistent.
- R10: Queued mode: `rd_stb` on an empty FIFO has no effect. The next pair written is read back from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | One-cycle strobe: a decoded pair is present |
| dev_code | input | 7 | Decoded device code |
| cmd_code | input | 8 | Decoded command code |
| irq_en_wr | input | 1 | Write strobe for the interrupt enable bit |
| irq_en_din | input | 1 | New value of the interrupt enable bit |
| ack | input | 1 | Direct mode: clear pending interrupt |
| rd_stb | input | 1 | Host read strobe: pops a byte (queued) or clears pending (direct) |
| rd_data | output | 8 | Queued mode: oldest FIFO byte, 0 when empty |
| dev_out | output | 7 | Direct mode: latest device code |
| cmd_out | output | 8 | Direct mode: latest command code |
| irq | output | 1 | Level interrupt |
| overflow | output | 1 | Queued mode: sticky dropped-pair flag |

## Verification
The bench builds two instances from the same inputs. One is queued with the default 8-byte FIFO, and one is direct. Both variants and their shared enable logic are therefore checked in a single run. A four-pair table fills the 8-byte queue exactly, which brings the full-FIFO drop and the sticky overflow within reach. A second fill starts from an odd occupancy, so it tests the boundary case of exactly one free byte. The direct instance is used to check overwrite while pending and an acknowledge that arrives together with a new pair.

// File: rtl/ir_host_pkg.sv
package ir_host_pkg;
   typedef enum logic {
      MODE_DIRECT = 1'b0,
      MODE_QUEUED = 1'b1
   } host_mode_e;

   localparam int unsigned IR_BYTE_W = 8;
endpackage

// File: rtl/ir_irq_enable.sv
module ir_irq_enable (
   input  logic clk,
   input  logic rst,
   input  logic wr,
   input  logic din,
   output logic en_q
);
   always_ff @(posedge clk) begin
      if (rst)     en_q <= 1'b0;
      else if (wr) en_q <= din;
   end

   // R5: enable only changes on a write
   a_r5_enable_holds: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(en_q));
endmodule

// File: rtl/ir_direct_regs.sv
module ir_direct_regs #(
   parameter int unsigned DEV_W = 7,
   parameter int unsigned CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [DEV_W-1:0] dev_in,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic             clear,
   output logic [DEV_W-1:0] dev_q,
   output logic [CMD_W-1:0] cmd_q,
   output logic             pend
);
   always_ff @(posedge clk) begin
      if (rst) begin
         dev_q <= '0;
         cmd_q <= '0;
         pend  <= 1'b0;
      end else if (load) begin
         dev_q <= dev_in;
         cmd_q <= cmd_in;
         pend  <= 1'b1;
      end else if (clear) begin
         pend  <= 1'b0;
      end
   end

   // R2: captured codes appear after the strobe edge
   a_r2_capture: assert property (@(posedge clk) disable iff (rst)
      load |=> (dev_q == $past(dev_in)) && (cmd_q == $past(cmd_in)));
   // R3: a new pair always leaves the flag pending, even alongside a clear
   a_r3_pending_on_load: assert property (@(posedge clk) disable iff (rst)
      load |=> pend);
   // R4: clear without a new pair drops pending
   a_r4_clear: assert property (@(posedge clk) disable iff (rst)
      (clear && !load) |=> !pend);
endmodule

// File: rtl/ir_byte_fifo.sv
module ir_byte_fifo #(
   parameter int unsigned DEV_W  = 7,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DEV_W-1:0]  dev_in,
   input  logic [BYTE_W-1:0] cmd_in,
   input  logic              pop,
   output logic [BYTE_W-1:0] head,
   output logic              empty,
   output logic              ovf
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam logic [PW:0] LIMIT = (PW+1)'(DEPTH - 2);
   localparam logic [PW:0] FULL  = (PW+1)'(DEPTH);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wptr, rptr;
   logic [PW:0]       count;
   logic              accept, do_pop;

   assign accept = push && (count <= LIMIT);
   assign do_pop = pop && (count != '0);
   assign empty  = (count == '0);
   assign head   = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (accept) begin
         mem[wptr]           <= {{(BYTE_W-DEV_W){1'b0}}, dev_in};
         mem[wptr + PW'(1)]  <= cmd_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (accept) wptr <= wptr + PW'(2);
         if (do_pop) rptr <= rptr + PW'(1);
         count <= count + (accept ? (PW+1)'(2) : '0) - (do_pop ? (PW+1)'(1) : '0);
         if (push && !accept) ovf <= 1'b1;
      end
   end

   // R8: occupancy never exceeds the storage
   a_r8_bound: assert property (@(posedge clk) disable iff (rst)
      count <= FULL);
   // R8: a pair arriving with fewer than two free bytes adds nothing
   a_r8_drop: assert property (@(posedge clk) disable iff (rst)
      (push && count > LIMIT) |=> (count + (PW+1)'($past(do_pop))) == $past(count));
   // R8: overflow is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);
   // R10: popping an empty queue leaves it untouched
   a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
      (pop && empty && !push) |=> empty && $stable(rptr));
endmodule

// File: rtl/ir_code_host_if.sv
module ir_code_host_if
   import ir_host_pkg::*;
#(
   parameter host_mode_e  MODE  = MODE_QUEUED,
   parameter int unsigned DEV_W = 7,
   parameter int unsigned CMD_W = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             code_valid,
   input  logic [DEV_W-1:0] dev_code,
   input  logic [CMD_W-1:0] cmd_code,
   input  logic             irq_en_wr,
   input  logic             irq_en_din,
   input  logic             ack,
   input  logic             rd_stb,
   output logic [IR_BYTE_W-1:0] rd_data,
   output logic [DEV_W-1:0] dev_out,
   output logic [CMD_W-1:0] cmd_out,
   output logic             irq,
   output logic             overflow
);
   initial begin
      assert (DEV_W >= 1 && DEV_W <= IR_BYTE_W) else $error("DEV_W must fit a byte");
      assert (CMD_W == IR_BYTE_W) else $error("CMD_W must equal the byte width");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("DEPTH must be a power of two >= 2");
   end

   logic en_q;

   ir_irq_enable u_en (
      .clk  (clk),
      .rst  (rst),
      .wr   (irq_en_wr),
      .din  (irq_en_din),
      .en_q (en_q)
   );

   generate
      if (MODE == MODE_QUEUED) begin : g_queued
         logic empty;
         logic sink_unused;
         assign sink_unused = ack;

         ir_byte_fifo #(.DEV_W(DEV_W), .BYTE_W(IR_BYTE_W), .DEPTH(DEPTH)) u_fifo (
            .clk    (clk),
            .rst    (rst),
            .push   (code_valid),
            .dev_in (dev_code),
            .cmd_in (cmd_code),
            .pop    (rd_stb),
            .head   (rd_data),
            .empty  (empty),
            .ovf    (overflow)
         );
         assign irq     = !empty && en_q;
         assign dev_out = '0;
         assign cmd_out = '0;
      end else begin : g_direct
         logic pend;

         ir_direct_regs #(.DEV_W(DEV_W), .CMD_W(CMD_W)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .load   (code_valid),
            .dev_in (dev_code),
            .cmd_in (cmd_code),
            .clear  (ack || rd_stb),
            .dev_q  (dev_out),
            .cmd_q  (cmd_out),
            .pend   (pend)
         );
         assign irq      = pend && en_q;
         assign rd_data  = '0;
         assign overflow = 1'b0;
      end
   endgenerate

   // R1: nothing is signalled in the cycle after a reset edge
   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!irq && !overflow));
   // R5: interrupt never shows while the enable is off
   a_r5_gated: assert property (@(posedge clk) disable iff (rst)
      (!en_q) |-> !irq);
endmodule

// File: tb/ir_code_host_if_tb.sv
`timescale 1ns/1ps
module ir_code_host_if_tb;
   import ir_host_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       code_valid = 1'b0;
   logic [6:0] dev_code = '0;
   logic [7:0] cmd_code = '0;
   logic       irq_en_wr = 1'b0, irq_en_din = 1'b0, ack = 1'b0, rd_stb = 1'b0;
   logic [7:0] q_rd, d_rd;
   logic [6:0] q_dev, d_dev;
   logic [7:0] q_cmd, d_cmd;
   logic       q_irq, d_irq, q_ovf, d_ovf;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   ir_code_host_if #(.MODE(MODE_QUEUED), .DEPTH(8)) u_dut (
      .clk(clk), .rst(rst), .code_valid(code_valid), .dev_code(dev_code),
      .cmd_code(cmd_code), .irq_en_wr(irq_en_wr), .irq_en_din(irq_en_din),
      .ack(ack), .rd_stb(rd_stb), .rd_data(q_rd), .dev_out(q_dev),
      .cmd_out(q_cmd), .irq(q_irq), .overflow(q_ovf));

   ir_code_host_if #(.MODE(MODE_DIRECT)) u_dir (
      .clk(clk), .rst(rst), .code_valid(code_valid), .dev_code(dev_code),
      .cmd_code(cmd_code), .irq_en_wr(irq_en_wr), .irq_en_din(irq_en_din),
      .ack(ack), .rd_stb(rd_stb), .rd_data(d_rd), .dev_out(d_dev),
      .cmd_out(d_cmd), .irq(d_irq), .overflow(d_ovf));

   localparam logic [14:0] VEC [4] = '{
      {7'h01, 8'h10}, {7'h7F, 8'h00}, {7'h2A, 8'hFF}, {7'h40, 8'h81}};

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic push(input logic [6:0] d, input logic [7:0] c);
      code_valid = 1'b1; dev_code = d; cmd_code = c;
      cyc();
      code_valid = 1'b0;
   endtask

   task automatic set_en(input logic v);
      irq_en_wr = 1'b1; irq_en_din = v;
      cyc();
      irq_en_wr = 1'b0;
   endtask

   task automatic pop_expect(input string tag, input logic [7:0] exp);
      check(tag, {8'h00, q_rd}, {8'h00, exp});
      rd_stb = 1'b1;
      cyc();
      rd_stb = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cyc(); cyc();
      rst = 1'b0;
   endtask

   initial begin
      #1_000_000;
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1;
      do_reset();
      // R1 reset state
      check("R1 q irq/ovf", {14'h0, q_irq, q_ovf}, 16'h0);
      check("R1 d irq", {15'h0, d_irq}, 16'h0);
      check("R1 d regs", {1'b0, d_dev, d_cmd}, 16'h0);

      // ---- direct mode ----
      push(7'h55, 8'hA3);
      check("R5 disabled irq", {15'h0, d_irq}, 16'h0);
      set_en(1'b1);
      check("R5 pending kept", {15'h0, d_irq}, 16'h1);
      check("R2 capture", {1'b0, d_dev, d_cmd}, {1'b0, 7'h55, 8'hA3});
      push(7'h12, 8'h34);
      check("R3 overwrite", {1'b0, d_dev, d_cmd}, {1'b0, 7'h12, 8'h34});
      check("R3 still pending", {15'h0, d_irq}, 16'h1);
      ack = 1'b1; cyc(); ack = 1'b0;
      check("R4 ack clears", {15'h0, d_irq}, 16'h0);
      push(7'h03, 8'h04);
      rd_stb = 1'b1; cyc(); rd_stb = 1'b0;
      check("R4 read clears", {15'h0, d_irq}, 16'h0);
      ack = 1'b1; push(7'h09, 8'h0A); ack = 1'b0;
      check("R4 new pair wins over ack", {15'h0, d_irq}, 16'h1);
      set_en(1'b0);
      check("R5 gate off", {15'h0, d_irq}, 16'h0);
      set_en(1'b1);
      check("R5 gate on again", {15'h0, d_irq}, 16'h1);

      // ---- queued mode: table fill ----
      do_reset();
      for (int i = 0; i < 4; i++) push(VEC[i][14:8], VEC[i][7:0]);
      check("R5 queued gated", {15'h0, q_irq}, 16'h0);
      set_en(1'b1);
      check("R7 irq not-empty", {15'h0, q_irq}, 16'h1);
      check("R8 no overflow yet", {15'h0, q_ovf}, 16'h0);
      push(7'h11, 8'h22);
      check("R8 overflow set", {15'h0, q_ovf}, 16'h1);
      for (int i = 0; i < 4; i++) begin
         pop_expect("R6 device byte", {1'b0, VEC[i][14:8]});
         pop_expect("R6 command byte", VEC[i][7:0]);
      end
      check("R7 irq empty / R8 pair dropped", {15'h0, q_irq}, 16'h0);
      check("R8 sticky", {15'h0, q_ovf}, 16'h1);
      rd_stb = 1'b1; cyc(); rd_stb = 1'b0;
      check("R10 empty pop irq", {15'h0, q_irq}, 16'h0);
      push(7'h7F, 8'hFF);
      check("R10 first byte after empty pop", {8'h0, q_rd}, 16'h007F);
      rd_stb = 1'b1; push(7'h01, 8'h80); rd_stb = 1'b0;
      pop_expect("R9 cmd after simultaneous", 8'hFF);
      pop_expect("R9 dev pushed with pop", 8'h01);
      pop_expect("R9 cmd pushed with pop", 8'h80);
      check("R9 count drained", {15'h0, q_irq}, 16'h0);

      // ---- queued mode: odd occupancy boundary ----
      do_reset();
      set_en(1'b1);
      check("R1 overflow cleared by reset", {15'h0, q_ovf}, 16'h0);
      push(7'h05, 8'h06);
      pop_expect("R6 dev before odd fill", 8'h05);
      push(7'h21, 8'h31);
      push(7'h22, 8'h32);
      push(7'h23, 8'h33);
      check("R8 seven bytes no overflow", {15'h0, q_ovf}, 16'h0);
      push(7'h24, 8'h34);
      check("R8 one free byte drops pair", {15'h0, q_ovf}, 16'h1);
      pop_expect("R8 seq 0", 8'h06);
      for (int i = 1; i < 4; i++) begin
         pop_expect("R8 seq dev", {1'b0, 7'h20 + 7'(i)});
         pop_expect("R8 seq cmd", 8'h30 + 8'(i));
      end
      check("R8 dropped pair absent", {15'h0, q_irq}, 16'h0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule